// File: doc/BRIEF.md
# Zero-Run Counter Unit

This unit measures the run of zero bits at one end of a 64-bit operand. A direction input picks the end: the run starts at the most significant bit (leading) or at the least significant bit (trailing). A size input picks the field: the whole 64 bits, or only the low 32 bits. A field with no set bit gives the full field width as the count. The count leaves the unit zero-extended to 64 bits, one clock after the request.

When the request carries its record flag, the unit also produces a 4-bit condition code. The code compares the count with zero and copies in a sticky-overflow bit supplied by the caller. The code register keeps its value on every request that does not set the flag.

The count comes from one combinational priority-encoder tree shared by all four modes. A single output register stage holds the result.

Top module: `zcnt_unit`

## Requirements
- R1: Leading, doubleword (trailing_i=0, word_i=0): count_o is the number of zero bits above the highest set bit of operand_i, with operand_i[63] the most significant bit; an all-zero operand gives 64.
- R2: Leading, word (trailing_i=0, word_i=1): only operand_i[31:0] is examined, with operand_i[31] first; operand_i[63:32] has no effect on the result; all-zero low word gives 32.
- R3: Trailing, doubleword (trailing_i=1, word_i=0): count_o is the number of zero bits below the lowest set bit, scanning upward from operand_i[0]; all-zero gives 64.
- R4: Trailing, word (trailing_i=1, word_i=1): same as R3 over operand_i[31:0] only; upper bits have no effect; all-zero low word gives 32.
- R5: count_o is zero-extended: bits [63:7] are always 0.
- R6: out_valid_o is high exactly in the cycle after a cycle with in_valid_i high, and count_o holds that request's result in that cycle.
- R7: For a request with record_i=1, cond_we_o is high with out_valid_o and cond_o = {lt, gt, eq, so} in bits [3:0], where lt=0, gt=(count!=0), eq=(count==0) and so=so_i sampled with the request.
- R8: For a request with record_i=0, cond_we_o stays low and cond_o keeps its previous value.
- R9: After reset, out_valid_o, cond_we_o, count_o and cond_o are all 0.
- R10: count_o keeps its value in cycles that follow a cycle with in_valid_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| operand_i | input | 64 | Value to scan |
| trailing_i | input | 1 | 1: count from bit 0 upward; 0: count from the top downward |
| word_i | input | 1 | 1: low 32-bit field only; 0: full 64 bits |
| record_i | input | 1 | Update the condition code for this request |
| so_i | input | 1 | Sticky-overflow bit copied into the condition code |
| out_valid_o | output | 1 | Result strobe, one cycle after in_valid_i |
| count_o | output | 64 | Zero-extended zero count |
| cond_we_o | output | 1 | Condition code written by this result |
| cond_o | output | 4 | Condition code {lt, gt, eq, so} |

## Verification
The assertions treat every input sampled at a rising edge as a complete request: they do not check for X values on operand_i or the mode bits while in_valid_i is high. They also assume reset is only asserted between requests. The bench meets both assumptions. It drives every input on the falling edge and leaves all of them defined from time zero. It releases reset before the first request, and it raises and drops in_valid_i only on falling edges.

// File: rtl/zcnt_pkg.sv
package zcnt_pkg;
  localparam int unsigned DATA_W = 64;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;
endpackage

// File: rtl/zcnt_prep.sv
// Folds direction and size into a single leading-zero scan vector.
module zcnt_prep #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic              trailing_i,
  input  logic              word_i,
  output logic [DATA_W-1:0] scan_o
);
  logic [DATA_W-1:0] rev_full;
  logic [HALF_W-1:0] rev_half;
  logic [HALF_W-1:0] low_sel;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_full
    assign rev_full[i] = operand_i[DATA_W-1-i];
  end
  for (genvar i = 0; i < HALF_W; i++) begin : g_rev_half
    assign rev_half[i] = operand_i[HALF_W-1-i];
  end

  assign low_sel = trailing_i ? rev_half : operand_i[HALF_W-1:0];

  // Sentinel one below the word caps the count at HALF_W.
  always_comb begin
    if (word_i) scan_o = {low_sel, 1'b1, {(HALF_W-1){1'b0}}};
    else        scan_o = trailing_i ? rev_full : operand_i;
  end
endmodule

// File: rtl/zcnt_tree.sv
// Balanced priority-encoder tree: leading zeros of vec_i.
module zcnt_tree #(
  parameter int unsigned W = 64,
  localparam int unsigned LVL = $clog2(W),
  localparam int unsigned CW = LVL + 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] lz_o,
  output logic          any_o
);
  logic          nv [LVL+1][W];
  logic [CW-1:0] nc [LVL+1][W];

  for (genvar n = 0; n < W; n++) begin : g_leaf
    assign nv[0][n] = vec_i[n];
    assign nc[0][n] = '0;
  end

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    localparam int unsigned NN = W >> (l + 1);
    for (genvar n = 0; n < W; n++) begin : g_node
      if (n < NN) begin : g_live
        // Child 2n+1 is the more significant half.
        assign nv[l+1][n] = nv[l][2*n+1] | nv[l][2*n];
        assign nc[l+1][n] = nv[l][2*n+1] ? nc[l][2*n+1]
                                         : (nc[l][2*n] | CW'(1 << l));
      end else begin : g_idle
        assign nv[l+1][n] = 1'b0;
        assign nc[l+1][n] = '0;
      end
    end
  end

  assign any_o = nv[LVL][0];
  assign lz_o  = any_o ? nc[LVL][0] : CW'(W);
endmodule

// File: rtl/zcnt_cond.sv
module zcnt_cond
  import zcnt_pkg::*;
#(
  parameter int unsigned CW = 7
) (
  input  logic [CW-1:0] count_i,
  input  logic          so_i,
  output cond_t         cond_o
);
  // A count is never negative, so lt stays clear.
  always_comb begin
    cond_o.lt = 1'b0;
    cond_o.eq = (count_i == '0);
    cond_o.gt = (count_i != '0);
    cond_o.so = so_i;
  end
endmodule

// File: rtl/zcnt_unit.sv
module zcnt_unit
  import zcnt_pkg::*;
#(
  parameter int unsigned DATA_W = zcnt_pkg::DATA_W,
  localparam int unsigned CW = $clog2(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              trailing_i,
  input  logic              word_i,
  input  logic              record_i,
  input  logic              so_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] count_o,
  output logic              cond_we_o,
  output logic [3:0]        cond_o
);
  logic [DATA_W-1:0] scan;
  logic [CW-1:0]     lz;
  logic              any_set;
  cond_t             cond_d;
  cond_t             cond_q;
  logic [CW-1:0]     count_q;
  logic              valid_q;
  logic              we_q;

  zcnt_prep #(.DATA_W(DATA_W)) u_prep (
    .operand_i (operand_i),
    .trailing_i(trailing_i),
    .word_i    (word_i),
    .scan_o    (scan)
  );

  zcnt_tree #(.W(DATA_W)) u_tree (
    .vec_i(scan),
    .lz_o (lz),
    .any_o(any_set)
  );

  zcnt_cond #(.CW(CW)) u_cond (
    .count_i(lz),
    .so_i   (so_i),
    .cond_o (cond_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      we_q    <= 1'b0;
      count_q <= '0;
      cond_q  <= '0;
    end else begin
      valid_q <= in_valid_i;
      we_q    <= in_valid_i & record_i;
      if (in_valid_i)            count_q <= lz;
      if (in_valid_i & record_i) cond_q  <= cond_d;
    end
  end

  assign out_valid_o = valid_q;
  assign count_o     = {{(DATA_W-CW){1'b0}}, count_q};
  assign cond_we_o   = we_q;
  assign cond_o      = cond_q;

  logic unused_any;
  assign unused_any = any_set;
endmodule

// File: rtl/zcnt_unit_chk.sv
module zcnt_unit_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] operand_i,
  input logic              trailing_i,
  input logic              word_i,
  input logic              record_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] count_o,
  input logic              cond_we_o,
  input logic [3:0]        cond_o
);
  // R6
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  // R6
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  // R5
  zero_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> count_o[DATA_W-1:7] == '0);
  // R2
  word_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && word_i |=> count_o <= DATA_W'(DATA_W/2));
  // R1
  lead_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !trailing_i && !word_i && operand_i[DATA_W-1] |=> count_o == '0);
  // R3
  trail_bottom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && trailing_i && operand_i[0] |=> count_o == '0);
  // R7
  cond_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_we_o |-> out_valid_o && !cond_o[3] && (cond_o[1] == (count_o == '0))
                  && (cond_o[2] == (count_o != '0)));
  // R8
  cond_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && record_i) |=> !cond_we_o && $stable(cond_o));
  // R10
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(count_o));
endmodule

bind zcnt_unit zcnt_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .operand_i  (operand_i),
  .trailing_i (trailing_i),
  .word_i     (word_i),
  .record_i   (record_i),
  .out_valid_o(out_valid_o),
  .count_o    (count_o),
  .cond_we_o  (cond_we_o),
  .cond_o     (cond_o)
);

// File: tb/zcnt_unit_test.sv
module zcnt_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic        trailing_i = 1'b0;
  logic        word_i = 1'b0;
  logic        record_i = 1'b0;
  logic        so_i = 1'b0;
  logic        out_valid_o;
  logic [63:0] count_o;
  logic        cond_we_o;
  logic [3:0]  cond_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [3:0]  exp_cond = '0;
  bit          done = 1'b0;

  zcnt_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .operand_i(operand_i), .trailing_i(trailing_i), .word_i(word_i),
    .record_i(record_i), .so_i(so_i), .out_valid_o(out_valid_o),
    .count_o(count_o), .cond_we_o(cond_we_o), .cond_o(cond_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic int ref_count(logic [63:0] op, bit trail, bit word);
    int w = word ? 32 : 64;
    int n = 0;
    bit hit = 0;
    for (int i = 0; i < w; i++) begin
      int idx = trail ? i : (w - 1 - i);
      if (!hit && op[idx]) hit = 1;
      if (!hit) n++;
    end
    return n;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string mode_req(bit trail, bit word);
    if (!trail && !word) return "R1";
    if (!trail && word)  return "R2";
    if (trail && !word)  return "R3";
    return "R4";
  endfunction

  // One request; result sampled just after the next rising edge.
  task automatic apply(logic [63:0] op, bit trail, bit word, bit rec, bit so);
    int e;
    @(negedge clk_i);
    in_valid_i = 1'b1; operand_i = op; trailing_i = trail;
    word_i = word; record_i = rec; so_i = so;
    e = ref_count(op, trail, word);
    @(posedge clk_i);
    #1;
    check("R6 valid", 64'(out_valid_o), 64'd1);
    check(mode_req(trail, word), count_o, 64'(e));
    check("R5 upper", 64'(count_o[63:7]), 64'd0);
    if (rec) begin
      exp_cond = {1'b0, e != 0, e == 0, so};
      check("R7 we", 64'(cond_we_o), 64'd1);
      check("R7 cond", 64'(cond_o), 64'(exp_cond));
    end else begin
      check("R8 we", 64'(cond_we_o), 64'd0);
      check("R8 cond", 64'(cond_o), 64'(exp_cond));
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R9 valid", 64'(out_valid_o), 64'd0);
    check("R9 count", count_o, 64'd0);
    check("R9 we", 64'(cond_we_o), 64'd0);
    check("R9 cond", 64'(cond_o), 64'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_walk_one();
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 64; k++)
        apply(64'd1 << k, m[0], m[1], k[0], k[1]);
    idle();
  endtask

  task automatic t_walk_zero();
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 64; k++)
        apply(~(64'd1 << k), m[0], m[1], k[2], k[0]);
    idle();
  endtask

  task automatic t_all_zero();
    for (int m = 0; m < 4; m++) begin
      apply(64'd0, m[0], m[1], 1'b1, m[0]);
      check(m[1] ? "R2 width" : "R1 width", count_o, m[1] ? 64'd32 : 64'd64);
    end
    // R2 R4: upper word set, low word clear
    apply(64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, 1'b1, 1'b0);
    apply(64'h8000_0000_0000_0000, 1'b1, 1'b1, 1'b0, 1'b0);
    idle();
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      logic [63:0] v = {$urandom(), $urandom()};
      int sh = $urandom_range(0, 63);
      v = (i % 2 == 0) ? (v >> sh) : (v << sh);
      apply(v, $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(0, 1));
      if (i % 7 == 0) idle();
    end
    idle();
  endtask

  task automatic t_hold();
    logic [63:0] snap;
    apply(64'h0000_0000_0010_0000, 1'b0, 1'b0, 1'b1, 1'b1);
    idle();
    snap = count_o;
    repeat (3) @(negedge clk_i);
    check("R10 count", count_o, snap);
    check("R6 idle", 64'(out_valid_o), 64'd0);
    check("R8 cond kept", 64'(cond_o), 64'(exp_cond));
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_walk_one();
    t_walk_zero();
    t_all_zero();
    t_random();
    t_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule